// File: doc/BRIEF.md
# Four-Channel Wiper and Backing Register Bank

This block holds the settings for four digitally stepped resistor dividers. Each channel owns one 8-bit wiper register, which is exported continuously to the resistor decoder, and four 8-bit backing registers that keep their content across resets. A serial front end decodes host transactions and presents one command per cycle. Each command carries an opcode, a channel number, a backing-register selector and a data byte. The block executes it the same cycle and returns read data, an error pulse or a busy indication on the following cycle.

The wiper can be written directly, loaded from any of its channel's backing registers, or stepped up or down by one position. A backing register can be written with a host byte or with the channel's current wiper value. Writes to backing storage model a slow non-volatile program cycle. They raise a busy flag for a programmable number of clock cycles, and they are refused while that flag is set or while the write-protect input is held low. At reset every wiper takes the value held in backing register 0 of its own channel.

Top module: `wiper_bank`

## Requirements
- R1: While rstN is low, at each clock edge every wiper register is loaded from backing register 0 of its own channel; backing registers keep their content through reset.
- R2: Opcode 1 writes cmdData to the wiper of cmdChan, visible on wiperOut after the next edge. Opcode 0 returns that wiper on rdData with rdValid high one cycle after the command. A wiper changes only when a command addresses it.
- R3: Opcode 6 raises the addressed wiper by one and opcode 7 lowers it by one. Both saturate: 0xFF stays at 0xFF and 0x00 stays at 0x00.
- R4: Opcode 4 loads the addressed wiper from backing register cmdSel of the same channel.
- R5: Opcode 3 writes cmdData to backing register cmdSel of cmdChan. Opcode 5 copies the channel's wiper into it. Opcode 2 returns a backing register on rdData with rdValid one cycle later.
- R6: An accepted backing write (opcode 3 or 5) drives busy high for exactly WR_CYCLES cycles, starting the cycle after the command. Wiper commands and reads are still carried out while busy is high.
- R7: A backing write issued while busy is high is refused: storage is unchanged, busy keeps its countdown, and cmdErr pulses high for one cycle.
- R8: A backing write issued while wrProtN is low is refused with a one-cycle cmdErr pulse. Wiper writes are unaffected by wrProtN.
- R9: Channel c's wiper appears on wiperOut bits [8c+7:8c]. The value 0x00 selects the tap at the low end of the divider and 0xFF selects the tap at the high end.
- R10: cmdErr is high only in the cycle after a refused backing write, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; recalls wipers |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode (0 rd wiper, 1 wr wiper, 2 rd backing, 3 wr backing, 4 load wiper, 5 store wiper, 6 step up, 7 step down) |
| cmdChan | input | 2 | Channel number |
| cmdSel | input | 2 | Backing register number within the channel |
| cmdData | input | 8 | Write data |
| wrProtN | input | 1 | Low blocks every backing write |
| busy | output | 1 | Backing write in progress |
| cmdErr | output | 1 | One-cycle pulse for a refused command |
| rdValid | output | 1 | rdData holds a read result |
| rdData | output | 8 | Read result |
| wiperOut | output | 32 | All wiper values, channel c at bits [8c+7:8c] |

## Verification
The checker watches, on every cycle, that wipers hold without a command, that stepping saturates at both ends, that busy rises only after an accepted backing write and lasts exactly the programmed time, and that an error pulse always follows a refused backing write. The bench scenarios cover what the checker cannot see from the ports. These are the recall of backing register 0 into each wiper under reset, the persistence of backing content across reset, and the read-back of a backing register after a refused write to show it was left intact. They also cover the interaction of random command streams with an in-flight write timer.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_BACK  = 3'd2,
    OP_WR_BACK  = 3'd3,
    OP_LOAD     = 3'd4,
    OP_STORE    = 3'd5,
    OP_STEP_UP  = 3'd6,
    OP_STEP_DN  = 3'd7
  } op_e;

  // strobes from control to datapath, already qualified by refusal logic
  typedef struct packed {
    logic wrWiper;
    logic loadWiper;
    logic stepUp;
    logic stepDn;
    logic wrBack;
    logic storeBack;
    logic rdWiper;
    logic rdBack;
  } strobe_t;

endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wiper_bank_pkg::*;
#(
  parameter int WR_CYCLES = 1000000,
  localparam int BCW = $clog2(WR_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       wrProtN,
  output strobe_t    stb,
  output logic       busy,
  output logic       cmdErr
);

  op_e op;
  logic isBackWr;
  logic refuse;
  logic [BCW-1:0] busyCnt;

  assign op       = op_e'(cmdOp);
  assign isBackWr = cmdValid && (op == OP_WR_BACK || op == OP_STORE);
  assign refuse   = isBackWr && (!wrProtN || busy);
  assign busy     = (busyCnt != '0);

  always_comb begin
    stb = '0;
    if (cmdValid && rstN) begin
      unique case (op)
        OP_RD_WIPER: stb.rdWiper   = 1'b1;
        OP_WR_WIPER: stb.wrWiper   = 1'b1;
        OP_RD_BACK:  stb.rdBack    = 1'b1;
        OP_WR_BACK:  stb.wrBack    = !refuse;
        OP_LOAD:     stb.loadWiper = 1'b1;
        OP_STORE:    stb.storeBack = !refuse;
        OP_STEP_UP:  stb.stepUp    = 1'b1;
        OP_STEP_DN:  stb.stepDn    = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  // program-cycle timer: counts system clocks of the slow backing write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      cmdErr  <= 1'b0;
    end else begin
      cmdErr <= refuse;
      if (isBackWr && !refuse)
        busyCnt <= BCW'(WR_CYCLES);
      else if (busy)
        busyCnt <= busyCnt - BCW'(1);
    end
  end

endmodule

// File: rtl/wb_dpath.sv
module wb_dpath
  import wiper_bank_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_BACK = 4,
  parameter int DW       = 8,
  localparam int CHW = $clog2(NUM_CH),
  localparam int SLW = $clog2(NUM_BACK)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [CHW-1:0]       cmdChan,
  input  logic [SLW-1:0]       cmdSel,
  input  logic [DW-1:0]        cmdData,
  output logic                 rdValid,
  output logic [DW-1:0]        rdData,
  output logic [NUM_CH*DW-1:0] wiperOut
);

  logic [NUM_CH-1:0][DW-1:0] wiperVec;
  logic [NUM_CH-1:0][DW-1:0] backVec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DW-1:0] wiperQ;
    logic [DW-1:0] backReg [NUM_BACK];
    logic hit;

    assign hit = (cmdChan == CHW'(c));

    // wiper: recall on reset, then direct, parallel or stepped update
    always_ff @(posedge clk) begin
      if (!rstN)
        wiperQ <= backReg[0];
      else if (hit) begin
        if (stb.wrWiper)
          wiperQ <= cmdData;
        else if (stb.loadWiper)
          wiperQ <= backReg[cmdSel];
        else if (stb.stepUp && wiperQ != '1)
          wiperQ <= wiperQ + DW'(1);
        else if (stb.stepDn && wiperQ != '0)
          wiperQ <= wiperQ - DW'(1);
      end
    end

    // backing storage carries no reset: it models persistent cells
    always_ff @(posedge clk) begin
      if (rstN && hit) begin
        if (stb.wrBack)
          backReg[cmdSel] <= cmdData;
        else if (stb.storeBack)
          backReg[cmdSel] <= wiperQ;
      end
    end

    assign wiperVec[c] = wiperQ;
    assign backVec[c]  = backReg[cmdSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdWiper || stb.rdBack;
      if (stb.rdWiper)
        rdData <= wiperVec[cmdChan];
      else if (stb.rdBack)
        rdData <= backVec[cmdChan];
    end
  end

  assign wiperOut = wiperVec;

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_BACK  = 4,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 1000000,
  localparam int CHW = $clog2(NUM_CH),
  localparam int SLW = $clog2(NUM_BACK)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [CHW-1:0]       cmdChan,
  input  logic [SLW-1:0]       cmdSel,
  input  logic [DW-1:0]        cmdData,
  input  logic                 wrProtN,
  output logic                 busy,
  output logic                 cmdErr,
  output logic                 rdValid,
  output logic [DW-1:0]        rdData,
  output logic [NUM_CH*DW-1:0] wiperOut
);

  strobe_t stb;

  wb_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .wrProtN(wrProtN), .stb(stb), .busy(busy), .cmdErr(cmdErr)
  );

  wb_dpath #(.NUM_CH(NUM_CH), .NUM_BACK(NUM_BACK), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdChan(cmdChan), .cmdSel(cmdSel),
    .cmdData(cmdData), .rdValid(rdValid), .rdData(rdData), .wiperOut(wiperOut)
  );

endmodule

// File: rtl/wb_chk.sv
module wb_chk #(
  parameter int NUM_CH    = 4,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 1000000,
  localparam int CHW = $clog2(NUM_CH),
  localparam int BCW = $clog2(WR_CYCLES + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [2:0]           cmdOp,
  input logic [CHW-1:0]       cmdChan,
  input logic                 wrProtN,
  input logic                 busy,
  input logic                 cmdErr,
  input logic                 rdValid,
  input logic [NUM_CH*DW-1:0] wiperOut
);

  logic backWr;
  logic isRead;
  logic [DW-1:0] curW;
  logic [BCW:0] busyRun;

  assign backWr = cmdValid && (cmdOp == 3'd3 || cmdOp == 3'd5);
  assign isRead = cmdValid && (cmdOp == 3'd0 || cmdOp == 3'd2);
  assign curW   = wiperOut[cmdChan*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + (BCW+1)'(1);
    else           busyRun <= '0;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(wiperOut));

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid);

  // R3
  step_up_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd6 && curW == '1 |=> $stable(wiperOut));

  // R3
  step_dn_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd7 && curW == '0 |=> $stable(wiperOut));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(backWr && wrProtN));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == (BCW+1)'(WR_CYCLES));

  // R8
  wp_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    backWr && !wrProtN |=> cmdErr);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> $past(backWr));

endmodule

bind wiper_bank wb_chk #(.NUM_CH(NUM_CH), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdChan(cmdChan),
  .wrProtN(wrProtN), .busy(busy), .cmdErr(cmdErr), .rdValid(rdValid),
  .wiperOut(wiperOut)
);

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
  localparam int NCH = 4;
  localparam int NBK = 4;
  localparam int DW  = 8;
  localparam int WRC = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cmdValid, wrProtN;
  logic [2:0] cmdOp;
  logic [1:0] cmdChan, cmdSel;
  logic [7:0] cmdData;
  logic busy, cmdErr, rdValid;
  logic [7:0] rdData;
  logic [31:0] wiperOut;

  wiper_bank #(.NUM_CH(NCH), .NUM_BACK(NBK), .DW(DW), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .cmdSel(cmdSel), .cmdData(cmdData), .wrProtN(wrProtN), .busy(busy),
    .cmdErr(cmdErr), .rdValid(rdValid), .rdData(rdData), .wiperOut(wiperOut)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit wKnown = 0;
  logic [7:0] mW [4];
  logic [7:0] mD [4][4];
  int mBusy = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stepUp(logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  function automatic logic [7:0] stepDn(logic [7:0] v);
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  function automatic logic [31:0] packW();
    return {mW[3], mW[2], mW[1], mW[0]};
  endfunction

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3, 3'd5: return "R5";
      3'd4: return "R4";
      default: return "R3";
    endcase
  endfunction

  // called at a negedge; applies one command and checks at the next negedge
  task automatic issue(logic [2:0] op, int ch, int sel, logic [7:0] d, logic wp);
    bit dw, refused, rd;
    logic [7:0] expRd;
    cmdValid = 1'b1; cmdOp = op; cmdChan = ch[1:0]; cmdSel = sel[1:0];
    cmdData = d; wrProtN = wp;
    dw = (op == 3'd3 || op == 3'd5);
    refused = dw && (!wp || mBusy != 0);
    rd = (op == 3'd0 || op == 3'd2);
    expRd = (op == 3'd0) ? mW[ch] : mD[ch][sel];
    case (op)
      3'd1: mW[ch] = d;
      3'd3: if (!refused) mD[ch][sel] = d;
      3'd4: mW[ch] = mD[ch][sel];
      3'd5: if (!refused) mD[ch][sel] = mW[ch];
      3'd6: mW[ch] = stepUp(mW[ch]);
      3'd7: mW[ch] = stepDn(mW[ch]);
      default: ;
    endcase
    if (dw && !refused) mBusy = WRC;
    else if (mBusy > 0) mBusy--;
    @(negedge clk);
    chk("R6 busy", {31'd0, busy}, {31'd0, mBusy != 0});
    chk(wp ? "R7 cmdErr" : "R8 cmdErr", {31'd0, cmdErr}, {31'd0, refused});
    chk("R2 rdValid", {31'd0, rdValid}, {31'd0, rd});
    if (rd) chk(tagOf(op), {24'd0, rdData}, {24'd0, expRd});
    if (wKnown) chk("R9 wiper fields", wiperOut, packW());
    cmdValid = 1'b0;
    wrProtN = 1'b1;
  endtask

  task automatic idle();
    cmdValid = 1'b0;
    if (mBusy > 0) mBusy--;
    @(negedge clk);
    chk("R6 busy idle", {31'd0, busy}, {31'd0, mBusy != 0});
    chk("R10 no error", {31'd0, cmdErr}, 32'd0);
    if (wKnown) chk("R2 hold", wiperOut, packW());
  endtask

  task automatic drain();
    while (mBusy > 0) idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; cmdValid = 1'b0; wrProtN = 1'b1;
    cmdOp = '0; cmdChan = '0; cmdSel = '0; cmdData = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset cmdErr", {31'd0, cmdErr}, 32'd0);
    chk("R2 reset rdValid", {31'd0, rdValid}, 32'd0);
    rstN = 1'b1;

    // fill backing storage (R5)
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) begin
        issue(3'd3, c, s, 8'(c * 16 + s * 3 + 5), 1'b1);
        drain();
      end

    // recall under reset (R1)
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 4; c++) mW[c] = mD[c][0];
    wKnown = 1;
    chk("R1 recall", wiperOut, packW());
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) issue(3'd2, 2, s, 8'h00, 1'b1);  // R1 storage kept

    // saturation (R3)
    issue(3'd1, 0, 0, 8'hFF, 1'b1);
    issue(3'd6, 0, 0, 8'h00, 1'b1);
    issue(3'd1, 1, 0, 8'h00, 1'b1);
    issue(3'd7, 1, 0, 8'h00, 1'b1);
    issue(3'd6, 1, 0, 8'h00, 1'b1);
    issue(3'd7, 0, 0, 8'h00, 1'b1);

    // load from last backing register (R4), store and read back (R5)
    issue(3'd4, 2, 3, 8'h00, 1'b1);
    issue(3'd1, 3, 0, 8'hA7, 1'b1);
    issue(3'd5, 3, 1, 8'h00, 1'b1);
    // R6: wiper commands proceed during busy; R7: second write refused
    issue(3'd1, 3, 0, 8'h3C, 1'b1);
    issue(3'd3, 3, 1, 8'h99, 1'b1);
    issue(3'd5, 0, 2, 8'h00, 1'b1);
    issue(3'd2, 3, 1, 8'h00, 1'b1);
    drain();
    issue(3'd2, 3, 1, 8'h00, 1'b1);
    issue(3'd2, 0, 2, 8'h00, 1'b1);

    // write protect (R8)
    issue(3'd3, 1, 2, 8'h55, 1'b0);
    issue(3'd5, 1, 3, 8'h00, 1'b0);
    issue(3'd1, 1, 0, 8'h81, 1'b0);
    issue(3'd2, 1, 2, 8'h00, 1'b1);
    issue(3'd2, 1, 3, 8'h00, 1'b1);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      issue(op, int'($urandom % 4), int'($urandom % 4), 8'($urandom),
            ($urandom % 6) != 0);
      if (($urandom % 4) == 0) idle();
    end
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule